// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Scheduler

This block picks which renamed instruction goes to execution next. It does not keep a window in which every entry watches every result. It keeps a few in-order queues. Each instruction that arrives from dispatch is placed directly behind its producer whenever that producer is still the youngest entry of a queue, so chains of dependent operations collect in the same queue. Each cycle the scheduler tests only the oldest entry of every queue. It tests that entry's source tags against a per-tag ready scoreboard. One ready entry per cycle is then sent to the issue port.

Dispatch delivers one instruction per cycle over a valid/ready handshake. Each instruction carries a destination tag and up to two source tags, and each source has its own use bit. The write-back side broadcasts one completed tag per cycle. A flush input discards everything in flight in a single cycle. Operand values, renaming and the execution units are outside this block.

Top module: `dep_fifo_sched`

## Requirements
- R1: After reset all queues are empty and every tag is marked ready. `disp_ready_o` is 1 and `issue_valid_o` is 0.
- R2: An instruction goes into the queue whose youngest entry's destination equals one of its used source tags. A source-0 match is preferred over a source-1 match, and the lowest queue index wins among equal matches. An empty queue never counts as a match.
- R3: When no queue matches, the instruction goes into the lowest-indexed empty queue.
- R4: `disp_ready_o` is 0 when no queue matches and none is empty. It is also 0 when the matching queue already holds DEPTH (default 8) entries.
- R5: Only the oldest entry of a queue may issue. It is eligible only when the ready bit of every source tag whose use bit is 1 is set.
- R6: An accepted dispatch clears the ready bit of its destination tag. A write-back sets the ready bit of its tag, and the change is visible to heads from the next cycle. If both hit the same tag in the same cycle, the bit ends cleared.
- R7: At most one instruction issues per cycle. Among eligible heads the lowest queue index wins, and `issue_q_o` gives that index.
- R8: While `flush_i` is 1, `disp_ready_o` and `issue_valid_o` are 0. After that cycle every queue is empty and every tag is ready.
- R9: An instruction accepted at a clock edge can issue in the following cycle at the earliest. A queue may be appended and popped in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all queued instructions, mark all tags ready |
| disp_valid_i | input | 1 | Dispatch offers an instruction |
| disp_ready_o | output | 1 | Instruction accepted this cycle |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_src0_i | input | TAG_W | Source 0 tag |
| disp_src0_use_i | input | 1 | Source 0 is used |
| disp_src1_i | input | TAG_W | Source 1 tag |
| disp_src1_use_i | input | 1 | Source 1 is used |
| wb_valid_i | input | 1 | Write-back broadcast valid |
| wb_tag_i | input | TAG_W | Tag being written back |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_dst_o | output | TAG_W | Issued destination tag |
| issue_src0_o | output | TAG_W | Issued source 0 tag |
| issue_src0_use_o | output | 1 | Issued source 0 used |
| issue_src1_o | output | TAG_W | Issued source 1 tag |
| issue_src1_use_o | output | 1 | Issued source 1 used |
| issue_q_o | output | $clog2(NUM_Q) | Queue the issued instruction came from |

## Verification
The checker watches four properties on every cycle. At most one queue pops. A full queue is never pushed. Every accepted dispatch lands in exactly one queue. Flush silences both handshakes and leaves nothing issuable in the next cycle.

Other behaviour can only be seen across a sequence, so directed scenarios cover it. These include where a consumer lands relative to its producer, and the preference for source 0. They also include the stall when every queue is busy or the target queue is full, the release order after a broadcast, and the tie between allocation and write-back on the same tag.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int unsigned TAG_W = 6;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    tag_t dst;
    tag_t src0;
    logic use0;
    tag_t src1;
    logic use1;
  } uop_t;
endpackage

// File: rtl/sched_fifo.sv
// In-order queue; tail_o is the youngest entry (valid when !empty_o).
module sched_fifo #(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  sched_pkg::uop_t   uop_i,
  input  logic              pop_i,
  output sched_pkg::uop_t   head_o,
  output sched_pkg::uop_t   tail_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  sched_pkg::uop_t mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q, last_idx;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= uop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign last_idx = (wr_q == '0) ? PW'(DEPTH - 1) : wr_q - PW'(1);
  assign head_o   = mem_q[rd_q];
  assign tail_o   = mem_q[last_idx];
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/sched_scoreboard.sv
// Per-tag ready bits; clear (allocation) wins over set on the same tag.
module sched_scoreboard #(
  parameter int unsigned TAG_W = sched_pkg::TAG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 set_i,
  input  logic [TAG_W-1:0]     set_tag_i,
  input  logic                 clr_i,
  input  logic [TAG_W-1:0]     clr_tag_i,
  output logic [2**TAG_W-1:0]  ready_o
);
  localparam int unsigned NTAG = 2 ** TAG_W;

  logic [NTAG-1:0] ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= '1;
    end else if (flush_i) begin
      ready_q <= '1;
    end else begin
      if (set_i) ready_q[set_tag_i] <= 1'b1;
      if (clr_i) ready_q[clr_tag_i] <= 1'b0;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/sched_steer.sv
// Picks the target queue: src0 tail hit, then src1 tail hit, then lowest empty.
module sched_steer #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned QW    = $clog2(NUM_Q)
) (
  input  sched_pkg::uop_t     uop_i,
  input  sched_pkg::tag_t     tail_dst_i [NUM_Q],
  input  logic [NUM_Q-1:0]    empty_i,
  input  logic [NUM_Q-1:0]    full_i,
  output logic                ok_o,
  output logic [QW-1:0]       sel_o
);
  logic [NUM_Q-1:0] hit0, hit1;
  logic             found;

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      hit0[q] = uop_i.use0 && !empty_i[q] && (tail_dst_i[q] == uop_i.src0);
      hit1[q] = uop_i.use1 && !empty_i[q] && (tail_dst_i[q] == uop_i.src1);
    end
    found = 1'b0;
    sel_o = '0;
    for (int q = NUM_Q - 1; q >= 0; q--)
      if (empty_i[q]) begin found = 1'b1; sel_o = QW'(q); end
    if (|hit1)
      for (int q = NUM_Q - 1; q >= 0; q--)
        if (hit1[q]) begin found = 1'b1; sel_o = QW'(q); end
    if (|hit0)
      for (int q = NUM_Q - 1; q >= 0; q--)
        if (hit0[q]) begin found = 1'b1; sel_o = QW'(q); end
    ok_o = found && !full_i[sel_o];
  end
endmodule

// File: rtl/sched_arb.sv
// Fixed priority, lowest index first.
module sched_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IW'(i);
    vld_o = |req_i;
    if (vld_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/dep_fifo_sched.sv
module dep_fifo_sched #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = sched_pkg::TAG_W,
  localparam int unsigned QW   = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             disp_valid_i,
  output logic             disp_ready_o,
  input  logic [TAG_W-1:0] disp_dst_i,
  input  logic [TAG_W-1:0] disp_src0_i,
  input  logic             disp_src0_use_i,
  input  logic [TAG_W-1:0] disp_src1_i,
  input  logic             disp_src1_use_i,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  output logic             issue_valid_o,
  output logic [TAG_W-1:0] issue_dst_o,
  output logic [TAG_W-1:0] issue_src0_o,
  output logic             issue_src0_use_o,
  output logic [TAG_W-1:0] issue_src1_o,
  output logic             issue_src1_use_o,
  output logic [QW-1:0]    issue_q_o
);
  sched_pkg::uop_t  disp_uop;
  sched_pkg::uop_t  head [NUM_Q];
  sched_pkg::uop_t  tail [NUM_Q];
  sched_pkg::tag_t  tail_dst [NUM_Q];
  sched_pkg::uop_t  iss_uop;
  logic [NUM_Q-1:0] empty, full, push, pop, head_rdy, req;
  logic [2**TAG_W-1:0] tag_rdy;
  logic             steer_ok, disp_fire, arb_vld;
  logic [QW-1:0]    steer_sel, arb_idx;

  assign disp_uop = '{dst: disp_dst_i, src0: disp_src0_i, use0: disp_src0_use_i,
                      src1: disp_src1_i, use1: disp_src1_use_i};

  assign disp_ready_o = steer_ok && !flush_i;
  assign disp_fire    = disp_valid_i && disp_ready_o;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    sched_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush_i),
      .push_i  (push[q]),
      .uop_i   (disp_uop),
      .pop_i   (pop[q]),
      .head_o  (head[q]),
      .tail_o  (tail[q]),
      .empty_o (empty[q]),
      .full_o  (full[q])
    );
    assign tail_dst[q] = tail[q].dst;
    assign push[q]     = disp_fire && (steer_sel == QW'(q));
    assign head_rdy[q] = !empty[q]
                         && (!head[q].use0 || tag_rdy[head[q].src0])
                         && (!head[q].use1 || tag_rdy[head[q].src1]);
  end

  sched_steer #(.NUM_Q(NUM_Q), .QW(QW)) u_steer (
    .uop_i      (disp_uop),
    .tail_dst_i (tail_dst),
    .empty_i    (empty),
    .full_i     (full),
    .ok_o       (steer_ok),
    .sel_o      (steer_sel)
  );

  sched_scoreboard #(.TAG_W(TAG_W)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .set_i     (wb_valid_i),
    .set_tag_i (wb_tag_i),
    .clr_i     (disp_fire),
    .clr_tag_i (disp_dst_i),
    .ready_o   (tag_rdy)
  );

  assign req = flush_i ? '0 : head_rdy;

  sched_arb #(.N(NUM_Q), .IW(QW)) u_arb (
    .req_i (req),
    .gnt_o (pop),
    .idx_o (arb_idx),
    .vld_o (arb_vld)
  );

  assign iss_uop          = head[arb_idx];
  assign issue_valid_o    = arb_vld;
  assign issue_dst_o      = iss_uop.dst;
  assign issue_src0_o     = iss_uop.src0;
  assign issue_src0_use_o = iss_uop.use0;
  assign issue_src1_o     = iss_uop.src1;
  assign issue_src1_use_o = iss_uop.use1;
  assign issue_q_o        = arb_idx;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int unsigned NUM_Q = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic             issue_valid_o,
  input logic [NUM_Q-1:0] pop_i,
  input logic [NUM_Q-1:0] push_i,
  input logic [NUM_Q-1:0] full_i
);
  assert_one_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_i));

  assert_flush_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!issue_valid_o && !disp_ready_o));

  assert_flush_drains_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !issue_valid_o);

  assert_no_push_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i & full_i) == '0);

  assert_single_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o) |-> ($countones(push_i) == 1));

  assert_no_push_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_valid_i && disp_ready_o) |-> (push_i == '0));
endmodule

bind dep_fifo_sched sched_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .disp_valid_i  (disp_valid_i),
  .disp_ready_o  (disp_ready_o),
  .issue_valid_o (issue_valid_o),
  .pop_i         (pop),
  .push_i        (push),
  .full_i        (full)
);

// File: tb/tb_dep_fifo_sched.sv
`timescale 1ns/1ps
module tb_dep_fifo_sched;
  localparam int TW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic disp_valid_i = 1'b0;
  logic disp_ready_o;
  logic [TW-1:0] disp_dst_i = '0, disp_src0_i = '0, disp_src1_i = '0;
  logic disp_src0_use_i = 1'b0, disp_src1_use_i = 1'b0;
  logic wb_valid_i = 1'b0;
  logic [TW-1:0] wb_tag_i = '0;
  logic issue_valid_o;
  logic [TW-1:0] issue_dst_o, issue_src0_o, issue_src1_o;
  logic issue_src0_use_o, issue_src1_use_o;
  logic [1:0] issue_q_o;

  int n_chk = 0, n_bad = 0;
  int lg_n = 0;
  int lg_dst [256];
  int lg_q [256];

  always #10 clk_i = ~clk_i;

  dep_fifo_sched dut (.*);

  // issue monitor: one sample per cycle, after inputs settle
  initial forever begin
    @(negedge clk_i);
    #2;
    if (rst_ni && issue_valid_o && lg_n < 256) begin
      lg_dst[lg_n] = issue_dst_o;
      lg_q[lg_n]   = issue_q_o;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic drive(input bit dv, input int d, input bit u0, input int s0,
                       input bit u1, input int s1, input bit wv, input int wt,
                       input bit fl);
    @(negedge clk_i);
    disp_valid_i = dv; disp_dst_i = TW'(d);
    disp_src0_use_i = u0; disp_src0_i = TW'(s0);
    disp_src1_use_i = u1; disp_src1_i = TW'(s1);
    wb_valid_i = wv; wb_tag_i = TW'(wt); flush_i = fl;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic disp(input int d, input bit u0, input int s0, input bit u1,
                      input int s1, input bit exp_rdy, input string r);
    drive(1, d, u0, s0, u1, s1, 0, 0, 0);
    chk(disp_ready_o == exp_rdy, r, disp_ready_o, exp_rdy);
  endtask

  task automatic wb(input int t);
    drive(0, 0, 0, 0, 0, 0, 1, t, 0);
  endtask

  task automatic chk_log(input int idx, input int d, input int q, input string r);
    chk(lg_n > idx, r, lg_n, idx + 1);
    if (lg_n > idx) begin
      chk(lg_dst[idx] == d, r, lg_dst[idx], d);
      chk(lg_q[idx] == q, r, lg_q[idx], q);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(disp_ready_o == 1'b1, "R1 ready", disp_ready_o, 1);
    chk(issue_valid_o == 1'b0, "R1 issue", issue_valid_o, 0);
  endtask

  task automatic t_single();
    disp(1, 0, 0, 0, 0, 1, "R3 accept");
    chk(issue_valid_o == 1'b0, "R9 no same-cycle issue", issue_valid_o, 0);
    idle(1);
    chk(issue_valid_o == 1'b1, "R9 next-cycle issue", issue_valid_o, 1);
    chk(issue_dst_o == 1, "R9 dst", issue_dst_o, 1);
    chk(issue_q_o == 0, "R3 q", issue_q_o, 0);
    idle(1);
  endtask

  task automatic t_chain();
    int b = lg_n;
    disp(2, 0, 0, 0, 0, 1, "R3 producer");
    disp(3, 1, 2, 0, 0, 1, "R2 consumer");
    idle(3);
    chk(lg_n == b + 1, "R5 consumer waits", lg_n - b, 1);
    wb(2);
    chk(issue_valid_o == 1'b0, "R6 wb visible next cycle", issue_valid_o, 0);
    idle(1);
    chk(issue_valid_o == 1'b1, "R6 wakeup", issue_valid_o, 1);
    chk(issue_dst_o == 3 && issue_q_o == 0, "R9 push/pop same queue",
        issue_dst_o, 3);
    idle(1);
  endtask

  task automatic t_spread();
    int b;
    disp(10, 0, 0, 0, 0, 1, "R3 blocker");
    idle(2);
    b = lg_n - 1;
    chk_log(b, 10, 0, "R3 blocker issue");
    b = lg_n;
    disp(11, 1, 10, 0, 0, 1, "R3 q0");
    disp(12, 1, 10, 0, 0, 1, "R3 q1");
    disp(13, 1, 10, 0, 0, 1, "R3 q2");
    disp(14, 1, 10, 0, 0, 1, "R3 q3");
    disp(15, 1, 10, 0, 0, 0, "R4 no empty queue");
    disp(16, 1, 12, 0, 0, 1, "R2 tail append");
    wb(10);
    idle(6);
    chk(lg_n == b + 4, "R5 behind-head holds", lg_n - b, 4);
    chk_log(b, 11, 0, "R7 order0");
    chk_log(b + 1, 12, 1, "R7 order1");
    chk_log(b + 2, 13, 2, "R7 order2");
    chk_log(b + 3, 14, 3, "R7 order3");
    wb(12);
    idle(2);
    chk_log(b + 4, 16, 1, "R2 appended entry");
  endtask

  task automatic t_full_flush();
    int b;
    disp(30, 0, 0, 0, 0, 1, "R3 head");
    idle(2);
    b = lg_n;
    for (int i = 0; i < 8; i++) disp(31 + i, 1, 30 + i, 0, 0, 1, "R2 fill");
    disp(39, 1, 38, 0, 0, 0, "R4 full queue");
    drive(1, 40, 1, 30, 0, 0, 0, 0, 1);
    chk(disp_ready_o == 1'b0, "R8 flush blocks dispatch", disp_ready_o, 0);
    chk(issue_valid_o == 1'b0, "R8 flush blocks issue", issue_valid_o, 0);
    disp(40, 1, 30, 0, 0, 1, "R8 accept after flush");
    idle(1);
    chk(issue_valid_o == 1'b1 && issue_dst_o == 40, "R8 tags ready",
        issue_dst_o, 40);
    chk(issue_q_o == 0, "R8 queues empty", issue_q_o, 0);
    idle(2);
    chk(lg_n == b + 1, "R8 flushed entries gone", lg_n - b, 1);
  endtask

  task automatic t_src1();
    int b;
    disp(45, 0, 0, 0, 0, 1, "R3 blocker");
    idle(2);
    b = lg_n;
    disp(46, 1, 45, 0, 0, 1, "R3 p1");
    disp(47, 1, 45, 0, 0, 1, "R3 p2");
    disp(48, 0, 0, 1, 47, 1, "R2 src1 hit");
    disp(49, 1, 46, 1, 48, 1, "R2 src0 preferred");
    wb(45);
    idle(4);
    chk(lg_n == b + 2, "R5 two released", lg_n - b, 2);
    chk_log(b, 46, 0, "R7 q0 first");
    chk_log(b + 1, 47, 1, "R7 q1 next");
    wb(47);
    idle(2);
    chk_log(b + 2, 48, 1, "R2 src1 landed q1");
    wb(46);
    wb(48);
    idle(2);
    chk_log(b + 3, 49, 0, "R2 src0 landed q0");
  endtask

  task automatic t_tie();
    int b;
    drive(1, 50, 0, 0, 0, 0, 1, 50, 0);
    chk(disp_ready_o == 1'b1, "R6 tie accept", disp_ready_o, 1);
    idle(2);
    b = lg_n;
    disp(51, 1, 50, 0, 0, 1, "R6 consumer");
    idle(3);
    chk(lg_n == b, "R6 alloc wins tie", lg_n - b, 0);
    wb(50);
    idle(2);
    chk_log(b, 51, 0, "R6 later wb wakes");
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_chain();
    t_spread();
    t_full_flush();
    t_src1();
    t_tie();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule